// File: doc/BRIEF.md
# Biphase-Mark Two-Channel Trigger Link Transmitter

This block is the transmit end of a one-way timing and trigger link. Two independent serial channels share one line. Channel A carries the first-level trigger bit, and channel B carries a serial command stream. The block interleaves the two channels in fixed bit slots, A then B. It then applies biphase-mark line coding, and the resulting single-bit symbol stream drives an optical transmitter.

The block runs on the symbol clock. Each data bit takes two symbol periods, so one A bit and one B bit together take four symbol clocks. Four symbol clocks also make one period of the system clock that the receivers recover. A free-running phase counter picks the slot and the half-cell. The block raises a strobe once per frame, so upstream logic can present the next trigger bit. Command bits arrive through a request/acknowledge pair. When no command is pending, channel B carries a zero.

Top module: `bmtx_link_tx`

## Requirements
- R1: While rst_ni is low, line_o, strobe_o and cmd_ack_o are 0. The first symbol period after reset is the first half of an A cell, and it is sent low.
- R2: A frame is four symbol periods in a fixed order: A first half, A second half, B first half, B second half (phases 0, 1, 2, 3).
- R3: line_o toggles at the start of every bit cell, that is on entering phase 0 and on entering phase 2.
- R4: On entering the A mid-cell (phase 1), line_o toggles only if the A bit is 1. The A bit is trig_i as sampled on the clock edge that enters phase 0.
- R5: On entering the B mid-cell (phase 3), line_o toggles only if the B bit is 1. The B bit is cmd_bit_i as sampled on the edge that enters phase 2, provided cmd_valid_i is 1 there.
- R6: strobe_o is high for exactly one symbol period per frame, during phase 3. The edge that ends that period samples the next A bit.
- R7: If cmd_valid_i is 1 on the edge that enters phase 2, cmd_ack_o is high for that one phase-2 period. At most one acknowledge is given per B slot.
- R8: If cmd_valid_i is 0 on the edge that enters phase 2, the B bit is 0 and cmd_ack_o stays low, whatever the value of cmd_bit_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock, four periods per frame |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger bit for channel A |
| cmd_valid_i | input | 1 | A command bit is pending |
| cmd_bit_i | input | 1 | Pending command bit for channel B |
| cmd_ack_o | output | 1 | Command bit taken for the current B slot |
| strobe_o | output | 1 | Frame strobe; the next A bit is sampled after it |
| line_o | output | 1 | Biphase-mark line symbol |

## Verification
The command acknowledge and the line toggle for the B cell start both happen on the edge that enters phase 2. In the same frame, the strobe of phase 3 coincides with the B mid-cell decision. The bench drives a new trigger bit and a new command on every strobe, including long runs of ones, alternating patterns and frames where cmd_bit_i is 1 while cmd_valid_i is 0. A scoreboard decodes the line cell by cell at mid-period. In the same frame it checks the acknowledge, the strobe position and both decoded bits against the queued expectation.

// File: rtl/bmtx_pkg.sv
package bmtx_pkg;
  localparam int unsigned PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_LEAD = 2'd0,
    PH_A_MID  = 2'd1,
    PH_B_LEAD = 2'd2,
    PH_B_MID  = 2'd3
  } phase_e;
endpackage

// File: rtl/bmtx_phase_gen.sv
module bmtx_phase_gen
  import bmtx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_q_o,
  output phase_e phase_n_o,
  output logic   strobe_o
);
  phase_e phase_q;
  logic   strobe_q;

  assign phase_n_o = phase_e'(phase_q + 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_A_LEAD;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_n_o;
      strobe_q <= (phase_n_o == PH_B_MID);
    end
  end

  assign phase_q_o = phase_q;
  assign strobe_o  = strobe_q;
endmodule

// File: rtl/bmtx_slot_mux.sv
module bmtx_slot_mux
  import bmtx_pkg::*;
#(
  parameter logic IDLE_CMD_BIT = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_n_i,
  input  logic   trig_i,
  input  logic   cmd_valid_i,
  input  logic   cmd_bit_i,
  output logic   a_bit_o,
  output logic   b_bit_o,
  output logic   ack_o
);
  logic a_q, b_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= 1'b0;
      b_q   <= IDLE_CMD_BIT;
      ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (phase_n_i == PH_A_LEAD) a_q <= trig_i;
      if (phase_n_i == PH_B_LEAD) begin
        b_q   <= cmd_valid_i ? cmd_bit_i : IDLE_CMD_BIT;
        ack_q <= cmd_valid_i;
      end
    end
  end

  assign a_bit_o = a_q;
  assign b_bit_o = b_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/bmtx_bm_coder.sv
module bmtx_bm_coder
  import bmtx_pkg::*;
#(
  parameter logic LINE_INIT = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_n_i,
  input  logic   a_bit_i,
  input  logic   b_bit_i,
  output logic   line_o
);
  logic line_q;
  logic flip;

  always_comb begin
    unique case (phase_n_i)
      PH_A_LEAD, PH_B_LEAD: flip = 1'b1;
      PH_A_MID:             flip = a_bit_i;
      PH_B_MID:             flip = b_bit_i;
      default:              flip = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= LINE_INIT;
    else         line_q <= line_q ^ flip;
  end

  assign line_o = line_q;
endmodule

// File: rtl/bmtx_link_tx.sv
module bmtx_link_tx
  import bmtx_pkg::*;
#(
  parameter logic LINE_INIT    = 1'b0,
  parameter logic IDLE_CMD_BIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic cmd_valid_i,
  input  logic cmd_bit_i,
  output logic cmd_ack_o,
  output logic strobe_o,
  output logic line_o
);
  phase_e phase_q, phase_n;
  logic   a_q, b_q;

  bmtx_phase_gen i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_q_o (phase_q),
    .phase_n_o (phase_n),
    .strobe_o  (strobe_o)
  );

  bmtx_slot_mux #(.IDLE_CMD_BIT(IDLE_CMD_BIT)) i_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_n_i   (phase_n),
    .trig_i      (trig_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_bit_i   (cmd_bit_i),
    .a_bit_o     (a_q),
    .b_bit_o     (b_q),
    .ack_o       (cmd_ack_o)
  );

  bmtx_bm_coder #(.LINE_INIT(LINE_INIT)) i_coder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_n_i (phase_n),
    .a_bit_i   (a_q),
    .b_bit_i   (b_q),
    .line_o    (line_o)
  );
endmodule

// File: rtl/bmtx_link_tx_chk.sv
module bmtx_link_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_o,
  input logic       strobe_o,
  input logic       cmd_ack_o,
  input logic       cmd_valid_i,
  input logic [1:0] phase_q,
  input logic       a_q,
  input logic       b_q
);
  p_cell_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q[0] |=> (line_o != $past(line_o)));

  p_a_mid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == 2'd0) |=> ((line_o != $past(line_o)) == $past(a_q)));

  p_b_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == 2'd2) |=> ((line_o != $past(line_o)) == $past(b_q)));

  p_strobe_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (phase_q == 2'd3));

  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  p_ack_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> (phase_q == 2'd2));

  p_ack_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_ack_o, strobe_o}));

  p_idle_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == 2'd1) && !cmd_valid_i) |=> (!cmd_ack_o && !b_q));

  p_frame_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_q == 2'($past(phase_q) + 2'd1)));
endmodule

bind bmtx_link_tx bmtx_link_tx_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_o      (line_o),
  .strobe_o    (strobe_o),
  .cmd_ack_o   (cmd_ack_o),
  .cmd_valid_i (cmd_valid_i),
  .phase_q     (phase_q),
  .a_q         (a_q),
  .b_q         (b_q)
);

// File: tb/test_bmtx_link_tx.sv
module test_bmtx_link_tx;
  localparam time CLK_PERIOD = 8ns;
  localparam int  N_FRAMES   = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_bit_i = 1'b0;
  logic cmd_ack_o, strobe_o, line_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {a, b, ack}
  logic [2:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bmtx_link_tx i_bmtx_link_tx (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_bit_i   (cmd_bit_i),
    .cmd_ack_o   (cmd_ack_o),
    .strobe_o    (strobe_o),
    .line_o      (line_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: decodes line per cell, compares with queue
  initial begin
    logic       prev;
    logic [2:0] cur;
    int         n;
    n = 0;
    prev = 1'b0;
    cur = 3'b000;
    wait (rst_ni);
    #1;
    forever begin
      case (n % 4)
        0: begin
          if (n == 0) chk("R1 first symbol low", line_o, 1'b0);
          else        chk("R3 toggle entering A cell", line_o, ~prev);
          chk("R6 strobe low in phase 0", strobe_o, 1'b0);
          chk("R7 no ack in phase 0", cmd_ack_o, 1'b0);
        end
        1: begin
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 scoreboard empty actual=0 expected=1");
          end else cur = exp_q.pop_front();
          chk("R4 A bit decode", line_o != prev, cur[2]);
          chk("R6 strobe low in phase 1", strobe_o, 1'b0);
        end
        2: begin
          chk("R3 toggle entering B cell", line_o, ~prev);
          chk("R7/R8 ack in B lead", cmd_ack_o, cur[0]);
          chk("R6 strobe low in phase 2", strobe_o, 1'b0);
        end
        default: begin
          chk("R5/R8 B bit decode", line_o != prev, cur[1]);
          chk("R6 strobe in phase 3", strobe_o, 1'b1);
          chk("R7 no ack in phase 3", cmd_ack_o, 1'b0);
        end
      endcase
      prev = line_o;
      n++;
      @(negedge clk);
      #1;
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  // driver
  initial begin
    logic [15:0] lfsr;
    logic        a, v, b;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1 line low in reset", line_o, 1'b0);
    chk("R1 strobe low in reset", strobe_o, 1'b0);
    chk("R1 ack low in reset", cmd_ack_o, 1'b0);
    exp_q.push_back(3'b000);
    rst_ni = 1'b1;
    for (int f = 0; f < N_FRAMES; f++) begin
      do @(negedge clk); while (!strobe_o);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (f < 16)      begin a = 1'b1; v = 1'b1; b = 1'b1; end
      else if (f < 32) begin a = 1'b0; v = 1'b1; b = 1'b0; end
      else if (f < 64) begin a = f[0]; v = 1'b1; b = ~f[0]; end
      else if (f < 96) begin a = f[1]; v = 1'b0; b = 1'b1; end // R8 bit ignored
      else             begin a = lfsr[0]; v = lfsr[1]; b = lfsr[2]; end
      trig_i      = a;
      cmd_valid_i = v;
      cmd_bit_i   = b;
      exp_q.push_back({a, v & b, v});
    end
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule